// File: doc/BRIEF.md
# Sequential Integer Divider with Divide Fault

This block divides a double-width dividend by a single-width divisor. It produces one quotient bit per clock and follows the classic accumulator-style divide rules. The dividend is formed by placing the high operand half above the low operand half. A two-bit size code selects an operand width of 8, 16 or 32 bits. A mode input selects unsigned or two's-complement division.

A successful divide returns the quotient in the position of the low half and the remainder in the position of the high half. The divide fails when the divisor is zero or the quotient does not fit the destination width. A failure raises a fault flag in place of the results, and the result outputs keep their previous contents. The surrounding pipeline starts an operation with a one-cycle `start` and watches `busy`. It takes the outcome on the single-cycle `done` pulse.

Signed division works on magnitudes through an unsigned restoring core. The quotient is negated when the operand signs differ. The remainder is negated when the dividend is negative. The quotient therefore truncates toward zero, and the remainder carries the sign of the dividend.

Top module: `idiv_seq`

## Requirements
- R1: Size code 0 selects 8-bit operands, code 1 selects 16-bit operands, and codes 2 and 3 select 32-bit operands. For width w, the dividend is the low w bits of `dvd_hi` placed above the low w bits of `dvd_lo`, and the divisor is the low w bits of `dvsr`. Operand bits above w are ignored. Results occupy the low w bits of `quot` and `rem`, and their upper bits are zero.
- R2: In unsigned mode (`is_signed`=0), a successful divide gives `quot` = dividend / divisor and `rem` = dividend mod divisor.
- R3: In unsigned mode, a quotient greater than 2^w-1 raises `fault` with `done`.
- R4: In signed mode (`is_signed`=1), the quotient is the true quotient truncated toward zero, and the remainder has the sign of the dividend with magnitude smaller than that of the divisor. Both are given as w-bit two's complement.
- R5: In signed mode, `fault` is raised when the quotient lies outside -2^(w-1) .. 2^(w-1)-1. A quotient of exactly -2^(w-1) succeeds.
- R6: A divisor whose low w bits are zero raises `done` and `fault` in the first cycle after the accepting edge, without iterating.
- R7: When `fault` is reported, `quot` and `rem` keep the values they held before the operation.
- R8: Call the clock edge that samples `start` while idle the accepting edge. For a nonzero divisor, `done` rises after the (2w+1)-th following edge, which is 2w+2 cycles counting the start cycle. `busy` is high in every cycle from the accepting edge until `done`, and low while `done` is high.
- R9: `done` is high for exactly one cycle per operation. `fault` is valid while `done` is high and is low for a successful divide.
- R10: A `start` that arrives while `busy` is high is ignored. The running operation completes with its own operands and timing.
- R11: After reset, `busy`, `done` and `fault` are low and `quot` and `rem` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request a divide; operands are sampled on the accepting edge |
| is_signed | input | 1 | 1 = two's-complement divide, 0 = unsigned |
| size | input | 2 | Operand width code: 0 = 8, 1 = 16, 2 or 3 = 32 bits |
| dvd_hi | input | W | Upper half of the dividend |
| dvd_lo | input | W | Lower half of the dividend |
| dvsr | input | W | Divisor |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | Divide fault, valid with done |
| quot | output | W | Quotient (low-half destination) |
| rem | output | W | Remainder (high-half destination) |

## Verification
The completion pulse of one divide can share a cycle with the acceptance of the next `start`. A zero-divisor request issued in that cycle even makes `done` rise again one cycle later. The bench provokes this by issuing the next operation in the very cycle `done` is seen. It then checks that the new operation's latency and results match the model, and that the results of the previous operation were not disturbed. The bench also raises `start` with unrelated operands in the middle of a running divide. The original operation must then finish with unchanged timing and values.

// File: rtl/idiv_pkg.sv
package idiv_pkg;
   localparam int unsigned BASE_W  = 8;
   localparam int unsigned N_SIZES = 3;

   typedef enum logic [1:0] {
      SZ_BYTE  = 2'd0,
      SZ_WORD  = 2'd1,
      SZ_DWORD = 2'd2,
      SZ_ALIAS = 2'd3
   } size_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RUN  = 2'd1,
      ST_FIN  = 2'd2
   } dstate_e;

   // code 3 behaves as the widest size
   function automatic logic [1:0] size_index(input logic [1:0] code);
      return (code == SZ_ALIAS) ? 2'(SZ_DWORD) : code;
   endfunction
endpackage

// File: rtl/idiv_prep.sv
module idiv_prep
   import idiv_pkg::*;
#(
   parameter int unsigned W  = 32,
   parameter int unsigned CW = $clog2(2*W+1)
) (
   input  logic            is_signed,
   input  logic [1:0]      sz_idx,
   input  logic [W-1:0]    hi,
   input  logic [W-1:0]    lo,
   input  logic [W-1:0]    dvsr,
   output logic [2*W-1:0]  dvd_mag,
   output logic [W-1:0]    dvs_mag,
   output logic            neg_q,
   output logic            neg_r,
   output logic            dvs_zero,
   output logic [CW-1:0]   iter_n
);
   localparam int unsigned DW = 2*W;

   logic [DW-1:0] al_a   [N_SIZES];
   logic [W-1:0]  bm_a   [N_SIZES];
   logic          sa_a   [N_SIZES];
   logic          sb_a   [N_SIZES];
   logic          zr_a   [N_SIZES];

   for (genvar k = 0; k < N_SIZES; k++) begin : g_size
      localparam int unsigned WK = BASE_W << k;
      logic [2*WK-1:0] raw;
      logic [2*WK-1:0] amag;
      logic [WK-1:0]   bmag;
      logic            sa, sb;
      assign raw  = {hi[WK-1:0], lo[WK-1:0]};
      assign sa   = is_signed & raw[2*WK-1];
      assign sb   = is_signed & dvsr[WK-1];
      assign amag = sa ? (~raw + 1'b1) : raw;
      assign bmag = sb ? (~dvsr[WK-1:0] + 1'b1) : dvsr[WK-1:0];
      // left-justify so the core always shifts out from its top bit
      assign al_a[k] = DW'(amag) << (DW - 2*WK);
      assign bm_a[k] = W'(bmag);
      assign sa_a[k] = sa;
      assign sb_a[k] = sb;
      assign zr_a[k] = (dvsr[WK-1:0] == '0);
   end

   always_comb begin
      dvd_mag  = al_a[sz_idx];
      dvs_mag  = bm_a[sz_idx];
      neg_q    = sa_a[sz_idx] ^ sb_a[sz_idx];
      neg_r    = sa_a[sz_idx];
      dvs_zero = zr_a[sz_idx];
      iter_n   = CW'(2 * (BASE_W << sz_idx));
   end
endmodule

// File: rtl/idiv_iter.sv
module idiv_iter #(
   parameter int unsigned W = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load,
   input  logic            step,
   input  logic [2*W-1:0]  dvd_in,
   input  logic [W-1:0]    dvs_in,
   output logic [2*W-1:0]  quo,
   output logic [W-1:0]    rem
);
   logic [2*W-1:0] sh_d, acc_q;
   logic [W-1:0]   acc_r, dvs_r;
   logic [W:0]     trial, diff;
   logic           ge;

   assign trial = {acc_r, sh_d[2*W-1]};
   assign diff  = trial - {1'b0, dvs_r};
   assign ge    = trial >= {1'b0, dvs_r};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_d  <= '0;
         acc_q <= '0;
         acc_r <= '0;
         dvs_r <= '0;
      end else if (load) begin
         sh_d  <= dvd_in;
         acc_q <= '0;
         acc_r <= '0;
         dvs_r <= dvs_in;
      end else if (step) begin
         sh_d  <= sh_d << 1;
         acc_q <= {acc_q[2*W-2:0], ge};
         acc_r <= ge ? diff[W-1:0] : trial[W-1:0];
      end
   end

   assign quo = acc_q;
   assign rem = acc_r;

   // R2: partial remainder stays below the divisor during iteration
   p_partial_rem_r2: assert property (@(posedge clk) disable iff (!rst_n)
      step |-> (acc_r < dvs_r));
endmodule

// File: rtl/idiv_post.sv
module idiv_post
   import idiv_pkg::*;
#(
   parameter int unsigned W = 32
) (
   input  logic            is_signed,
   input  logic [1:0]      sz_idx,
   input  logic            neg_q,
   input  logic            neg_r,
   input  logic [2*W-1:0]  quo_mag,
   input  logic [W-1:0]    rem_mag,
   output logic [W-1:0]    q_res,
   output logic [W-1:0]    r_res,
   output logic            fits
);
   localparam int unsigned DW = 2*W;

   logic [W-1:0] q_a  [N_SIZES];
   logic [W-1:0] r_a  [N_SIZES];
   logic         ok_a [N_SIZES];

   for (genvar k = 0; k < N_SIZES; k++) begin : g_size
      localparam int unsigned WK = BASE_W << k;
      localparam logic [DW-1:0] LIM = DW'(1) << (WK-1);
      logic [DW-1:0] qn;
      logic [W-1:0]  rn;
      logic          ok_u, ok_s;
      assign ok_u = (quo_mag[DW-1:WK] == '0);
      assign ok_s = neg_q ? (quo_mag <= LIM) : (quo_mag < LIM);
      assign qn   = neg_q ? (~quo_mag + 1'b1) : quo_mag;
      assign rn   = neg_r ? (~rem_mag + 1'b1) : rem_mag;
      assign q_a[k]  = W'(qn[WK-1:0]);
      assign r_a[k]  = W'(rn[WK-1:0]);
      assign ok_a[k] = is_signed ? ok_s : ok_u;
   end

   always_comb begin
      q_res = q_a[sz_idx];
      r_res = r_a[sz_idx];
      fits  = ok_a[sz_idx];
   end
endmodule

// File: rtl/idiv_seq.sv
module idiv_seq
   import idiv_pkg::*;
#(
   parameter int unsigned W = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          is_signed,
   input  logic [1:0]    size,
   input  logic [W-1:0]  dvd_hi,
   input  logic [W-1:0]  dvd_lo,
   input  logic [W-1:0]  dvsr,
   output logic          busy,
   output logic          done,
   output logic          fault,
   output logic [W-1:0]  quot,
   output logic [W-1:0]  rem
);
   localparam int unsigned CW = $clog2(2*W+1);

   if (W < (BASE_W << (N_SIZES-1))) begin : g_bad_width
      $error("idiv_seq: W must cover the widest operand size");
   end

   dstate_e        st;
   logic [CW-1:0]  cnt;
   logic           sgn_r, nq_r, nr_r;
   logic [1:0]     szi_r;
   logic           done_r, fault_r;
   logic [W-1:0]   quot_r, rem_r;

   logic [1:0]     szi_in;
   logic [2*W-1:0] dvd_mag, core_q;
   logic [W-1:0]   dvs_mag, core_r, q_res, r_res;
   logic           neg_q, neg_r, dvs_zero, fits, accept;
   logic [CW-1:0]  iter_n;

   assign szi_in = size_index(size);
   assign accept = start && (st == ST_IDLE);

   idiv_prep #(.W(W), .CW(CW)) i_prep (
      .is_signed (is_signed),
      .sz_idx    (szi_in),
      .hi        (dvd_hi),
      .lo        (dvd_lo),
      .dvsr      (dvsr),
      .dvd_mag   (dvd_mag),
      .dvs_mag   (dvs_mag),
      .neg_q     (neg_q),
      .neg_r     (neg_r),
      .dvs_zero  (dvs_zero),
      .iter_n    (iter_n)
   );

   idiv_iter #(.W(W)) i_iter (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (accept && !dvs_zero),
      .step   (st == ST_RUN),
      .dvd_in (dvd_mag),
      .dvs_in (dvs_mag),
      .quo    (core_q),
      .rem    (core_r)
   );

   idiv_post #(.W(W)) i_post (
      .is_signed (sgn_r),
      .sz_idx    (szi_r),
      .neg_q     (nq_r),
      .neg_r     (nr_r),
      .quo_mag   (core_q),
      .rem_mag   (core_r),
      .q_res     (q_res),
      .r_res     (r_res),
      .fits      (fits)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= ST_IDLE;
         cnt     <= '0;
         sgn_r   <= 1'b0;
         nq_r    <= 1'b0;
         nr_r    <= 1'b0;
         szi_r   <= '0;
         done_r  <= 1'b0;
         fault_r <= 1'b0;
         quot_r  <= '0;
         rem_r   <= '0;
      end else begin
         done_r <= 1'b0;
         unique case (st)
            ST_IDLE: if (start) begin
               sgn_r <= is_signed;
               nq_r  <= neg_q;
               nr_r  <= neg_r;
               szi_r <= szi_in;
               if (dvs_zero) begin
                  done_r  <= 1'b1;
                  fault_r <= 1'b1;
               end else begin
                  cnt <= iter_n;
                  st  <= ST_RUN;
               end
            end
            ST_RUN: begin
               cnt <= cnt - 1'b1;
               if (cnt == CW'(1)) st <= ST_FIN;
            end
            ST_FIN: begin
               done_r  <= 1'b1;
               fault_r <= !fits;
               if (fits) begin
                  quot_r <= q_res;
                  rem_r  <= r_res;
               end
               st <= ST_IDLE;
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign busy  = (st != ST_IDLE);
   assign done  = done_r;
   assign fault = fault_r;
   assign quot  = quot_r;
   assign rem   = rem_r;

   // R6: zero divisor is reported on the very next cycle
   p_zero_quick_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy && dvs_zero) |=> (done && fault));
   // R7: a fault leaves the destinations untouched
   p_fault_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (done && fault) |-> ($stable(quot) && $stable(rem)));
   // R8: completion is reported from the idle state
   p_idle_at_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);
   // R9: done lasts a single cycle unless a new zero-divisor request follows
   p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !start) |=> !done);
   // R10: a running divide only ends through completion
   p_busy_ends_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done);
endmodule

// File: tb/test_idiv_seq.sv
`timescale 1ns/1ps
module test_idiv_seq;
   localparam int W = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic          is_signed = 1'b0;
   logic [1:0]    size = 2'd0;
   logic [W-1:0]  dvd_hi = '0, dvd_lo = '0, dvsr = '0;
   logic          busy, done, fault;
   logic [W-1:0]  quot, rem;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   idiv_seq #(.W(W)) i_idiv_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .is_signed(is_signed),
      .size(size), .dvd_hi(dvd_hi), .dvd_lo(dvd_lo), .dvsr(dvsr),
      .busy(busy), .done(done), .fault(fault), .quot(quot), .rem(rem)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input longint unsigned act, input longint unsigned exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic void model(input bit sg, input bit [1:0] sz,
                                 input bit [31:0] hi, input bit [31:0] lo,
                                 input bit [31:0] d, output bit flt,
                                 output bit [31:0] q, output bit [31:0] r,
                                 output int w);
      bit [63:0] m2, dvd, am, qm, rm, lim;
      bit [31:0] m1, dv, bm;
      bit sa, sb, ng;
      w   = (sz == 2'd0) ? 8 : (sz == 2'd1) ? 16 : 32;
      m2  = (64'd1 << (2*w)) - 64'd1;
      m1  = (w == 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 32'd1);
      dvd = (64'(hi & m1) << w) | 64'(lo & m1);
      dv  = d & m1;
      q = '0; r = '0; flt = 1'b0;
      if (dv == 0) begin flt = 1'b1; return; end
      sa = sg && dvd[2*w-1];
      sb = sg && dv[w-1];
      ng = sa ^ sb;
      am = sa ? ((~dvd + 64'd1) & m2) : dvd;
      bm = sb ? ((~dv + 32'd1) & m1) : dv;
      qm = am / 64'(bm);
      rm = am % 64'(bm);
      lim = 64'd1 << (w-1);
      if (!sg) flt = (qm > 64'(m1));
      else     flt = ng ? (qm > lim) : (qm >= lim);
      q = 32'(ng ? (~qm + 64'd1) : qm) & m1;
      r = 32'(sa ? (~rm + 64'd1) : rm) & m1;
   endfunction

   // caller is at a negedge; returns at the negedge where done is seen
   task automatic run_op(input bit sg, input bit [1:0] sz, input bit [31:0] hi,
                         input bit [31:0] lo, input bit [31:0] d,
                         input bit poke, input bit chain);
      bit flt; bit [31:0] eq, er, pq, pr; int w, c, lat;
      string tag;
      model(sg, sz, hi, lo, d, flt, eq, er, w);
      pq = quot; pr = rem;
      is_signed = sg; size = sz; dvd_hi = hi; dvd_lo = lo; dvsr = d; start = 1'b1;
      @(negedge clk);
      start = 1'b0; c = 1;
      // scramble operands: they must have been captured on the accepting edge
      is_signed = ~sg; size = $urandom; dvd_hi = $urandom; dvd_lo = $urandom; dvsr = 0;
      while (!done && c < 200) begin
         if (poke && c == 3) begin start = 1'b1; dvsr = $urandom; end
         else start = 1'b0;
         @(negedge clk);
         c++;
      end
      start = 1'b0;
      lat = ((d & ((w == 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 1))) == 0) ? 1 : 2*w + 2;
      tag = (lat == 1) ? "R6" : (poke ? "R10" : "R8");
      check(c == lat, tag, "latency", c, lat);
      check(!busy, "R8", "busy at done", busy, 0);
      tag = (lat == 1) ? "R6" : (sg ? "R5" : "R3");
      check(fault == flt, tag, "fault", fault, flt);
      if (!flt) begin
         tag = poke ? "R10" : (sg ? "R4" : "R2");
         check(quot == eq, tag, "quotient", quot, eq);
         check(rem == er, tag, "remainder", rem, er);
      end else begin
         check(quot == pq && rem == pr, "R7", "results held on fault",
               {quot, rem}, {pq, pr});
      end
      if (!chain) begin
         @(negedge clk);
         check(!done, "R9", "done single cycle", done, 0);
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual hung expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd24681));
      repeat (3) @(negedge clk);
      // R11: reset state
      check(!busy && !done && !fault, "R11", "status after reset", {busy, done, fault}, 0);
      check(quot == 0 && rem == 0, "R11", "results after reset", {quot, rem}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      // R2 unsigned byte and the maximum fitting quotient
      run_op(0, 2'd0, 32'h01, 32'h00, 32'h10, 0, 0);
      run_op(0, 2'd0, 32'h0F, 32'hFF, 32'h10, 0, 0);
      // R3 unsigned overflow, R7 results kept
      run_op(0, 2'd0, 32'h10, 32'h00, 32'h10, 0, 0);
      // R6 zero divisor, word; only low bits of divisor count (R1)
      run_op(0, 2'd1, 32'h1, 32'h2, 32'hABCD_0000, 0, 0);
      // R4 signed truncation toward zero with remainder signs
      run_op(1, 2'd0, 32'hFF, 32'hF9, 32'h02, 0, 0);
      run_op(1, 2'd0, 32'h00, 32'h07, 32'hFE, 0, 0);
      // R5 signed boundary: -128 fits, +128 faults
      run_op(1, 2'd0, 32'hFF, 32'h00, 32'h02, 0, 0);
      run_op(1, 2'd0, 32'h01, 32'h00, 32'h02, 0, 0);
      // R5 most negative doubleword dividend divided by -1
      run_op(1, 2'd2, 32'h8000_0000, 32'h0, 32'hFFFF_FFFF, 0, 0);
      // R1 size code 3 acts as doubleword; junk above byte width ignored
      run_op(0, 2'd3, 32'h0000_1234, 32'h5678_9ABC, 32'h0001_0000, 0, 0);
      run_op(0, 2'd0, 32'hABCD_1201, 32'h7777_7734, 32'hFFFF_FF13, 0, 0);
      // R10 start while busy
      run_op(0, 2'd1, 32'h0012, 32'h3456, 32'h0100, 1, 0);
      // R9/R8 back-to-back: next start in the done cycle, then a zero divisor
      run_op(1, 2'd1, 32'hFFFF, 32'h8001, 32'h0007, 0, 1);
      run_op(0, 2'd0, 32'h00, 32'h00, 32'h00, 0, 1);
      run_op(0, 2'd0, 32'h00, 32'h55, 32'h05, 0, 0);
      for (int i = 0; i < 300; i++) begin
         bit sg; bit [1:0] sz; bit [31:0] hi, lo, d; int k;
         sg = $urandom; sz = $urandom; lo = $urandom; d = $urandom;
         if ($urandom % 6 == 0) d = d & 32'hF;
         k = $urandom % 4;
         case (k)
            0: hi = $urandom;
            1: hi = 0;
            2: hi = 32'hFFFF_FFFF;
            default: hi = $urandom % ((d >> 1) | 1);
         endcase
         run_op(sg, sz, hi, lo, d, ($urandom % 8) == 0, ($urandom % 4) == 0);
      end
      @(negedge clk);
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule